// File: doc/BRIEF.md
# Dual-Capture Up-Counting Timer

This block is a 16-bit up-counter with two capture registers, one compare register and a toggle output flip-flop. The counter advances on one of four sources: rising edges of the first capture pin, or one of three prescaled tick enables supplied from outside. When a match with the compare register occurs, the counter can be cleared to zero. Otherwise it runs freely and wraps.

A two-bit capture mode selects three things at once: which edges load each capture register, and which edge of the first capture pin raises the interrupt. The edge sources are the two capture pins and a trigger from a companion timer. Software can also snapshot the counter into capture register 0. It does this by writing a 0 into the one-shot capture bit of the mode register.

The toggle flip-flop can invert on a compare match, on every load of capture register 1, or on both. All external inputs pass through a two-flop synchronizer before use. The interrupt request is a single-cycle pulse.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode register reads 0x20, the compare and both capture registers read 0, and `tff_o` and `irq_o` are 0. The register addresses are: 0 mode, 1 compare, 2 capture 0, 3 capture 1. The mode bits are: [1:0] clock select, [2] clear enable, [4:3] capture mode, [5] software capture, [6] toggle on match, [7] toggle on capture-1 load.
- R2: The clock select picks the counter increment source: 00 rising edges of `cap_pin0_i`, 01 `tick_t1_i`, 10 `tick_t4_i`, 11 `tick_t16_i`. Unselected sources have no effect.
- R3: With clear enable at 1, a count tick taken while the counter equals the compare value sets the counter to 0.
- R4: With clear enable at 0, the counter runs freely and wraps from 0xFFFF to 0.
- R5: Capture mode 00 loads neither capture register from any pin or trigger edge. The interrupt fires on a rising edge of `cap_pin0_i`.
- R6: Capture mode 01 loads capture 0 on a rising edge of `cap_pin0_i` and capture 1 on a rising edge of `cap_pin1_i`. The interrupt fires on a rising edge of `cap_pin0_i`.
- R7: Capture mode 10 loads capture 0 on a rising edge and capture 1 on a falling edge of `cap_pin0_i`. The interrupt fires on the falling edge only.
- R8: Capture mode 11 loads capture 0 on a rising edge and capture 1 on a falling edge of `trig_i`. The interrupt fires on a rising edge of `cap_pin0_i`.
- R9: A mode write with bit 5 at 0 copies the counter into capture 0. A write with bit 5 at 1 leaves capture 0 unchanged. Bit 5 always reads 1.
- R10: With bit 6 set, `tff_o` inverts on each count tick taken while the counter equals the compare value.
- R11: With bit 7 set, `tff_o` inverts on each load of capture 1.
- R12: `irq_o` is high for exactly one cycle per qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| cap_pin0_i | input | 1 | Capture pin 0, also the external count input |
| cap_pin1_i | input | 1 | Capture pin 1 |
| trig_i | input | 1 | Trigger from the companion timer |
| tick_t1_i | input | 1 | Prescaled tick enable T1 |
| tick_t4_i | input | 1 | Prescaled tick enable T4 |
| tick_t16_i | input | 1 | Prescaled tick enable T16 |
| tff_o | output | 1 | Toggle flip-flop output |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
A corrupted counter shows up only at the next capture, so each scenario stops the tick sources and then snapshots the counter through capture 0 or 1. A wrong count therefore appears in capture data within a few cycles of the event. A wrong edge decode in a capture mode shows up in two ways: the wrong capture register changes, or the interrupt count differs, and either is seen about three cycles after the pin changes, once the signal has passed the synchronizer. A stuck or mistimed toggle flip-flop is visible on `tff_o` within one cycle of the match tick or the capture-1 load.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    SRC_PIN = 2'b00, SRC_T1 = 2'b01, SRC_T4 = 2'b10, SRC_T16 = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    CAP_OFF = 2'b00, CAP_TWO_PINS = 2'b01, CAP_PIN0_BOTH = 2'b10, CAP_TRIG_BOTH = 2'b11
  } cap_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAP0 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAP1 = 2'd3;

  localparam int MB_CLR    = 2;
  localparam int MB_SWCAP  = 5;
  localparam int MB_TGL_M  = 6;
  localparam int MB_TGL_C1 = 7;
  localparam int MODE_W    = 8;

  localparam int N_IN   = 3;
  localparam int IN_P0  = 0;
  localparam int IN_P1  = 1;
  localparam int IN_TRG = 2;
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prv_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  // history for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= '0;
    else         prv_q <= stg_q[STAGES-1];
  end

  assign lvl_o = stg_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/ct_counter.sv
module ct_counter
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  clk_src_e         clk_sel_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             pin0_rise_i,
  input  logic             tick_t1_i,
  input  logic             tick_t4_i,
  input  logic             tick_t16_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;
  logic             hit;

  always_comb begin
    unique case (clk_sel_i)
      SRC_PIN: cnt_en = pin0_rise_i;
      SRC_T1:  cnt_en = tick_t1_i;
      SRC_T4:  cnt_en = tick_t4_i;
      default: cnt_en = tick_t16_i;
    endcase
  end

  assign hit     = (cnt_q == cmp_i);
  assign match_o = cnt_en & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_en) begin
      if (clr_en_i && hit)         cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en |=> $stable(cnt_q));
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !(clr_en_i && hit)) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R3
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && clr_en_i) |=> cnt_q == '0);
endmodule

// File: rtl/ct_capture.sv
module ct_capture
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cap_mode_e        cap_mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [N_IN-1:0]  lvl_i,
  input  logic [N_IN-1:0]  prv_i,
  input  logic             sw_cap_i,
  input  logic             match_i,
  input  logic             tgl_match_en_i,
  input  logic             tgl_cap1_en_i,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             tff_o,
  output logic             irq_o
);
  logic [N_IN-1:0]  rise, fall;
  logic             hw0, ld1, irq_evt, tgl_evt;
  logic [CNT_W-1:0] cap0_q, cap1_q;
  logic             tff_q, irq_q;

  assign rise = lvl_i & ~prv_i;
  assign fall = ~lvl_i & prv_i;

  always_comb begin
    hw0     = 1'b0;
    ld1     = 1'b0;
    irq_evt = rise[IN_P0];
    unique case (cap_mode_i)
      CAP_TWO_PINS: begin
        hw0 = rise[IN_P0];
        ld1 = rise[IN_P1];
      end
      CAP_PIN0_BOTH: begin
        hw0     = rise[IN_P0];
        ld1     = fall[IN_P0];
        irq_evt = fall[IN_P0];
      end
      CAP_TRIG_BOTH: begin
        hw0 = rise[IN_TRG];
        ld1 = fall[IN_TRG];
      end
      default: ;
    endcase
  end

  assign tgl_evt = (match_i & tgl_match_en_i) | (ld1 & tgl_cap1_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap0_q <= '0;
      cap1_q <= '0;
      tff_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // hardware capture wins over the software snapshot
      if (hw0)           cap0_q <= cnt_i;
      else if (sw_cap_i) cap0_q <= cnt_i;
      if (ld1)           cap1_q <= cnt_i;
      if (tgl_evt)       tff_q  <= ~tff_q;
      irq_q <= irq_evt;
    end
  end

  assign cap0_o = cap0_q;
  assign cap1_o = cap1_q;
  assign tff_o  = tff_q;
  assign irq_o  = irq_q;

  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R5
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i == CAP_OFF && !sw_cap_i) |=> ($stable(cap0_q) && $stable(cap1_q)));
  // R6
  cap1_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i == CAP_TWO_PINS && rise[IN_P1]) |=> cap1_q == $past(cnt_i));
  // R10
  tff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(match_i && tgl_match_en_i) && !(ld1 && tgl_cap1_en_i)) |=> $stable(tff_q));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              cap_pin0_i,
  input  logic              cap_pin1_i,
  input  logic              trig_i,
  input  logic              tick_t1_i,
  input  logic              tick_t4_i,
  input  logic              tick_t16_i,
  output logic              tff_o,
  output logic              irq_o
);
  clk_src_e         clk_sel_q;
  cap_mode_e        cap_mode_q;
  logic             clr_en_q, tgl_m_q, tgl_c1_q;
  logic [CNT_W-1:0] cmp_q;
  logic             mode_wr, sw_cap;
  logic [N_IN-1:0]  lvl, prv;
  logic [CNT_W-1:0] cnt, cap0, cap1;
  logic             match;
  logic [MODE_W-1:0] mode_rd;

  assign mode_wr = we_i && (addr_i == A_MODE);
  assign sw_cap  = mode_wr && !wdata_i[MB_SWCAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q  <= SRC_PIN;
      cap_mode_q <= CAP_OFF;
      clr_en_q   <= 1'b0;
      tgl_m_q    <= 1'b0;
      tgl_c1_q   <= 1'b0;
      cmp_q      <= '0;
    end else if (we_i) begin
      if (addr_i == A_MODE) begin
        clk_sel_q  <= clk_src_e'(wdata_i[1:0]);
        clr_en_q   <= wdata_i[MB_CLR];
        cap_mode_q <= cap_mode_e'(wdata_i[4:3]);
        tgl_m_q    <= wdata_i[MB_TGL_M];
        tgl_c1_q   <= wdata_i[MB_TGL_C1];
      end else if (addr_i == A_CMP) begin
        cmp_q <= wdata_i;
      end
    end
  end

  // software capture bit is a one-shot and reads back as 1
  assign mode_rd = {tgl_c1_q, tgl_m_q, 1'b1, cap_mode_q, clr_en_q, clk_sel_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE:  rdata_o[MODE_W-1:0] = mode_rd;
      A_CMP:   rdata_o = cmp_q;
      A_CAP0:  rdata_o = cap0;
      default: rdata_o = cap1;
    endcase
  end

  ct_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({trig_i, cap_pin1_i, cap_pin0_i}),
    .lvl_o  (lvl),
    .prv_o  (prv)
  );

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_sel_i   (clk_sel_q),
    .clr_en_i    (clr_en_q),
    .cmp_i       (cmp_q),
    .pin0_rise_i (lvl[IN_P0] & ~prv[IN_P0]),
    .tick_t1_i   (tick_t1_i),
    .tick_t4_i   (tick_t4_i),
    .tick_t16_i  (tick_t16_i),
    .cnt_o       (cnt),
    .match_o     (match)
  );

  ct_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cap_mode_i     (cap_mode_q),
    .cnt_i          (cnt),
    .lvl_i          (lvl),
    .prv_i          (prv),
    .sw_cap_i       (sw_cap),
    .match_i        (match),
    .tgl_match_en_i (tgl_m_q),
    .tgl_cap1_en_i  (tgl_c1_q),
    .cap0_o         (cap0),
    .cap1_o         (cap1),
    .tff_o          (tff_o),
    .irq_o          (irq_o)
  );

  // R9
  sw_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_cap && cap_mode_q == CAP_OFF) |=> cap0 == $past(cnt));
  // R1
  mode_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MODE) |-> rdata_o[MB_SWCAP]);
endmodule

// File: tb/cap_timer_test.sv
module cap_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         pin0 = 1'b0, pin1 = 1'b0, trig = 1'b0;
  logic         t1 = 1'b0, t4 = 1'b0, t16 = 1'b0;
  logic         tff, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_pin0_i(pin0), .cap_pin1_i(pin1), .trig_i(trig),
    .tick_t1_i(t1), .tick_t4_i(t4), .tick_t16_i(t16), .tff_o(tff), .irq_o(irq)
  );

  always @(posedge clk) if (rst_ni && irq) irq_cnt <= irq_cnt + 1;

  function automatic logic [W-1:0] mode(input logic [1:0] sel, input logic clr,
                                        input logic [1:0] cm, input logic sw,
                                        input logic tm, input logic tc);
    return {8'h00, tc, tm, sw, cm, clr, sel};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; we = 0; pin0 = 0; pin1 = 0; trig = 0; t1 = 0; t4 = 0; t16 = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        1: t1 = 1'b1;
        4: t4 = 1'b1;
        default: t16 = 1'b1;
      endcase
      @(negedge clk);
      t1 = 1'b0; t4 = 1'b0; t16 = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // snapshot the counter through capture 0 (mode bits rewritten unchanged)
  task automatic snap(input logic [W-1:0] m, output logic [W-1:0] v);
    wr(2'd0, m & ~16'h0020);
    rd(2'd2, v);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    do_reset();
    rd(2'd0, v); chk("R1 mode", v, 16'h0020);
    rd(2'd1, v); chk("R1 cmp", v, 16'h0000);
    rd(2'd2, v); chk("R1 cap0", v, 16'h0000);
    rd(2'd3, v); chk("R1 cap1", v, 16'h0000);
    chk("R1 tff", {15'd0, tff}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_clk_sel();
    logic [W-1:0] v, m;
    do_reset();
    m = mode(2'b01, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(1, 3); pulse(4, 2); pulse(16, 2);
    snap(m, v); chk("R2 sel01", v, 16'd3);
    m = mode(2'b10, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(4, 2); pulse(1, 1); pulse(16, 1);
    snap(m, v); chk("R2 sel10", v, 16'd5);
    m = mode(2'b11, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(16, 4); pulse(4, 1); pulse(1, 1);
    snap(m, v); chk("R2 sel11", v, 16'd9);
    m = mode(2'b00, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); pin0 = 1; settle();
      @(negedge clk); pin0 = 0; settle();
    end
    pulse(1, 1);
    snap(m, v); chk("R2 sel00", v, 16'd11);
  endtask

  task automatic t_clear();
    logic [W-1:0] v, m;
    do_reset();
    wr(2'd1, 16'd3);
    m = mode(2'b01, 1, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(1, 5);
    snap(m, v); chk("R3 clear at match", v, 16'd1);
  endtask

  task automatic t_wrap();
    logic [W-1:0] v, m;
    do_reset();
    wr(2'd1, 16'h1234);
    m = mode(2'b01, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(1, 2);
    @(negedge clk); t1 = 1'b1;
    repeat (1 << W) @(negedge clk);
    t1 = 1'b0;
    snap(m, v); chk("R4 wrap", v, 16'd2);
  endtask

  task automatic t_sw();
    logic [W-1:0] v, m;
    do_reset();
    m = mode(2'b01, 0, 2'b00, 1, 0, 0); wr(2'd0, m);
    pulse(1, 6);
    snap(m, v); chk("R9 sw capture", v, 16'd6);
    pulse(1, 2);
    wr(2'd0, m);
    rd(2'd2, v); chk("R9 write 1 ignored", v, 16'd6);
    rd(2'd0, v); chk("R9 bit reads 1", v, m);
  endtask

  task automatic t_mode00();
    logic [W-1:0] v;
    int base;
    do_reset();
    wr(2'd0, mode(2'b01, 0, 2'b00, 1, 0, 0));
    pulse(1, 3);
    base = irq_cnt;
    @(negedge clk); pin0 = 1; pin1 = 1; trig = 1; settle();
    @(negedge clk); pin0 = 0; pin1 = 0; trig = 0; settle();
    rd(2'd2, v); chk("R5 cap0 idle", v, 16'd0);
    rd(2'd3, v); chk("R5 cap1 idle", v, 16'd0);
    chk("R5 irq on rise", 16'(irq_cnt - base), 16'd1);
  endtask

  task automatic t_mode01();
    logic [W-1:0] v;
    int base;
    do_reset();
    wr(2'd0, mode(2'b01, 0, 2'b01, 1, 0, 0));
    base = irq_cnt;
    pulse(1, 5);
    @(negedge clk); pin1 = 1; settle();
    rd(2'd3, v); chk("R6 cap1 pin1 rise", v, 16'd5);
    rd(2'd2, v); chk("R6 cap0 untouched", v, 16'd0);
    pulse(1, 3);
    @(negedge clk); pin0 = 1; settle();
    rd(2'd2, v); chk("R6 cap0 pin0 rise", v, 16'd8);
    rd(2'd3, v); chk("R6 cap1 held", v, 16'd5);
    @(negedge clk); pin0 = 0; pin1 = 0; settle();
    chk("R6 irq count", 16'(irq_cnt - base), 16'd1);
  endtask

  task automatic t_mode10();
    logic [W-1:0] v;
    int base;
    do_reset();
    wr(2'd0, mode(2'b01, 0, 2'b10, 1, 0, 1));
    base = irq_cnt;
    pulse(1, 4);
    @(negedge clk); pin0 = 1; settle();
    rd(2'd2, v); chk("R7 cap0 rise", v, 16'd4);
    chk("R7 no irq on rise", 16'(irq_cnt - base), 16'd0);
    chk("R11 tff before", {15'd0, tff}, 16'd0);
    pulse(1, 2);
    @(negedge clk); pin0 = 0; settle();
    rd(2'd3, v); chk("R7 cap1 fall", v, 16'd6);
    chk("R7 irq on fall", 16'(irq_cnt - base), 16'd1);
    chk("R12 one pulse per edge", 16'(irq_cnt - base), 16'd1);
    chk("R11 tff after load", {15'd0, tff}, 16'd1);
    @(negedge clk); pin1 = 1; settle();
    rd(2'd3, v); chk("R7 pin1 ignored", v, 16'd6);
    @(negedge clk); pin0 = 1; settle();
    @(negedge clk); pin0 = 0; settle();
    chk("R11 tff second load", {15'd0, tff}, 16'd0);
  endtask

  task automatic t_mode11();
    logic [W-1:0] v;
    int base;
    do_reset();
    wr(2'd0, mode(2'b01, 0, 2'b11, 1, 0, 0));
    base = irq_cnt;
    pulse(1, 7);
    @(negedge clk); trig = 1; settle();
    rd(2'd2, v); chk("R8 cap0 trig rise", v, 16'd7);
    pulse(1, 1);
    @(negedge clk); trig = 0; settle();
    rd(2'd3, v); chk("R8 cap1 trig fall", v, 16'd8);
    chk("R8 trig no irq", 16'(irq_cnt - base), 16'd0);
    @(negedge clk); pin0 = 1; settle();
    chk("R8 irq pin0 rise", 16'(irq_cnt - base), 16'd1);
    rd(2'd2, v); chk("R8 pin0 no capture", v, 16'd7);
  endtask

  task automatic t_tgl_match();
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, mode(2'b01, 0, 2'b00, 1, 1, 0));
    pulse(1, 2);
    chk("R10 no toggle yet", {15'd0, tff}, 16'd0);
    pulse(1, 1);
    chk("R10 toggle on match", {15'd0, tff}, 16'd1);
    pulse(1, 2);
    chk("R10 held past match", {15'd0, tff}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_clk_sel();
    t_clear();
    t_sw();
    t_mode00();
    t_mode01();
    t_mode10();
    t_mode11();
    t_tgl_match();
    t_wrap();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule